// File: doc/BRIEF.md
# Buffered 16-bit Timer / Event Counter

This block is an up-counter of twice the bus width (16 bits by default) that software programs and reads over a byte-wide register bus. The counter can advance in three ways. It can step on cycles where an internal tick-enable input is high (timer). It can step on a chosen edge of an external input (event counting). It can step on internal ticks while the external input stays at its active level, which measures a pulse width. When the count passes its all-ones value, the counter reloads from a preload value and raises a one-cycle interrupt pulse.

The bus can only move one byte per access, so a shared low-byte holding register makes each 16-bit transfer coherent. A write to the low address is parked in the holding register. A write to the high address then commits both bytes to the preload at once. A read of the high address returns the high count byte and, in the same cycle, copies the low count byte into the holding register. A later read of the low address returns the low half of that same snapshot.

Top module: `evt_timer16`

## Requirements
- R1: After reset the count, preload, holding register and control byte are all zero, and `irq_o` is low.
- R2: A write to the low address (default 1) changes only the holding register. The count and preload keep their values, and a read of the low address returns the written byte.
- R3: A write to the high address (default 0) sets the preload to {write data, holding register} in one cycle. If the run bit is clear, the same value is also loaded into the count.
- R4: A read of the high address returns count[15:8] and copies count[7:0] into the holding register. A read of the low address returns the holding register.
- R5: The control byte at address 2 reads back bits [7:6] as the mode, bit 4 as the run bit and bit 3 as the edge select. Bits 5 and 2..0 always read 0. Address 3 reads 0.
- R6: In timer mode (control bits [7:6] = 10) with the run bit set, the count advances by one on each clock cycle where `tick_i` is high.
- R7: In event mode (01) with the run bit set, the count advances by one for each active edge of `ext_i` after a two-flop synchronizer. Edge select 0 means rising and 1 means falling, and `tick_i` is ignored.
- R8: The count does not move while the run bit is clear, or while mode 00 is selected, apart from loads by high-address writes.
- R9: When the count advances from all ones, it reloads from the preload. `irq_o` is then high for exactly the following cycle.
- R10: A high-address write while the run bit is set updates the preload but leaves the count unchanged.
- R11: In pulse-width mode (11), the counter waits for an active edge. It then counts ticks while `ext_i` stays at the active level. On the opposite edge it stops and the hardware clears the run bit.
- R12: Between loads and reloads, the count changes by at most +1 per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Internal count tick enable |
| ext_i | input | 1 | Asynchronous external event / gate input |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_o | output | 1 | One-cycle overflow pulse |

## Verification
The assertions assume that a write strobe and a read strobe never fall in the same cycle. They also assume that `ext_i` holds each level long enough for the synchronizer to see it. The bench drives every bus access as a single strobe at one address. It keeps each external pulse high and low for at least four clocks. It holds random preloads below the wrap point unless wrap is the case under test, so the expected counts follow from simple arithmetic on the start value and the number of ticks or edges.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_PULSE = 2'b11
   } tmr_mode_e;

   // Control byte layout (software-visible positions)
   localparam int CTL_MODE_HI = 7;
   localparam int CTL_MODE_LO = 6;
   localparam int CTL_RUN     = 4;
   localparam int CTL_EDGE    = 3;
   localparam logic [7:0] CTL_MASK = 8'hD8;

   function automatic tmr_mode_e ctl_mode(input logic [7:0] c);
      return tmr_mode_e'(c[CTL_MODE_HI:CTL_MODE_LO]);
   endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   input  logic fall_sel,
   output logic lvl,
   output logic act_lvl,
   output logic hit,
   output logic rel
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              rise_w;
   logic              fall_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      lvl     = chain_q[STAGES-1];
      rise_w  = lvl & ~prev_q;
      fall_w  = ~lvl & prev_q;
      hit     = fall_sel ? fall_w : rise_w;
      rel     = fall_sel ? rise_w : fall_w;
      act_lvl = lvl ^ fall_sel;
   end

endmodule

// File: rtl/evt_regif.sv
module evt_regif
   import evt_timer16_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 2,
   parameter logic [ADDR_W-1:0] A_HI  = 0,
   parameter logic [ADDR_W-1:0] A_LO  = 1,
   parameter logic [ADDR_W-1:0] A_CTL = 2,
   localparam int CNT_W = 2 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              pw_done,
   output logic [CNT_W-1:0]  preload,
   output logic [BUS_W-1:0]  hold,
   output logic [7:0]        ctl,
   output logic              load,
   output logic [CNT_W-1:0]  load_val
);

   logic wr_hi, wr_lo, wr_ctl, rd_hi;

   always_comb begin
      wr_hi    = wr && (addr == A_HI);
      wr_lo    = wr && (addr == A_LO);
      wr_ctl   = wr && (addr == A_CTL);
      rd_hi    = rd && (addr == A_HI);
      load_val = {wdata, hold};
      load     = wr_hi && !ctl[CTL_RUN];
   end

   // holding register: bus writes of the low byte, snapshot on high read
   always_ff @(posedge clk) begin
      if (!rst_n)     hold <= '0;
      else if (wr_lo) hold <= wdata;
      else if (rd_hi) hold <= cnt[BUS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     preload <= '0;
      else if (wr_hi) preload <= load_val;
   end

   // control: software write has priority over the hardware run clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         ctl <= '0;
      else if (wr_ctl)
         ctl <= wdata[7:0] & CTL_MASK;
      else if (pw_done)
         ctl[CTL_RUN] <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == A_HI)       rdata = cnt[CNT_W-1:BUS_W];
      else if (addr == A_LO)  rdata = hold;
      else if (addr == A_CTL) rdata = ctl;
   end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
   import evt_timer16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmr_mode_e        mode,
   input  logic             run,
   input  logic             hit,
   input  logic             rel,
   input  logic             act_lvl,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] preload,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap_q,
   output logic             pw_done
);

   logic pw_meas_q;
   logic adv;
   logic at_top;

   always_comb begin
      adv = 1'b0;
      unique case (mode)
         MODE_TIMER: adv = tick;
         MODE_EVENT: adv = hit;
         MODE_PULSE: adv = pw_meas_q && act_lvl && tick;
         default:    adv = 1'b0;
      endcase
      adv     = adv && run;
      at_top  = &cnt;
      pw_done = run && (mode == MODE_PULSE) && pw_meas_q && rel;
   end

   // pulse-width phase: waiting for active edge vs measuring
   always_ff @(posedge clk) begin
      if (!rst_n)
         pw_meas_q <= 1'b0;
      else if (!run || mode != MODE_PULSE || pw_done)
         pw_meas_q <= 1'b0;
      else if (hit)
         pw_meas_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         wrap_q <= 1'b0;
      end else begin
         wrap_q <= adv && at_top;
         if (load)
            cnt <= load_val;
         else if (adv)
            cnt <= at_top ? preload : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
   import evt_timer16_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] A_HI  = 0,
   parameter logic [ADDR_W-1:0] A_LO  = 1,
   parameter logic [ADDR_W-1:0] A_CTL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ext_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq_o
);

   localparam int CNT_W = 2 * BUS_W;

   generate
      if (BUS_W != 8) begin : g_bad_bus
         $error("evt_timer16: control layout needs an 8-bit bus");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("evt_timer16: at least two synchronizer stages required");
      end
      if (A_HI == A_LO || A_HI == A_CTL || A_LO == A_CTL) begin : g_bad_map
         $error("evt_timer16: register addresses must be distinct");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] preload_val;
   logic [CNT_W-1:0] load_val;
   logic [BUS_W-1:0] hold_val;
   logic [7:0]       ctl_val;
   logic             load;
   logic             pw_done;
   logic             ext_lvl, ext_act, ext_hit, ext_rel;
   logic             run_bit;
   tmr_mode_e        mode_val;

   always_comb begin
      run_bit  = ctl_val[CTL_RUN];
      mode_val = ctl_mode(ctl_val);
   end

   evt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (ext_i),
      .fall_sel (ctl_val[CTL_EDGE]),
      .lvl      (ext_lvl),
      .act_lvl  (ext_act),
      .hit      (ext_hit),
      .rel      (ext_rel)
   );

   evt_regif #(
      .BUS_W (BUS_W), .ADDR_W (ADDR_W),
      .A_HI (A_HI), .A_LO (A_LO), .A_CTL (A_CTL)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .wdata    (bus_wdata),
      .rdata    (bus_rdata),
      .cnt      (cnt_val),
      .pw_done  (pw_done),
      .preload  (preload_val),
      .hold     (hold_val),
      .ctl      (ctl_val),
      .load     (load),
      .load_val (load_val)
   );

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_i),
      .mode     (mode_val),
      .run      (run_bit),
      .hit      (ext_hit),
      .rel      (ext_rel),
      .act_lvl  (ext_act),
      .load     (load),
      .load_val (load_val),
      .preload  (preload_val),
      .cnt      (cnt_val),
      .wrap_q   (irq_o),
      .pw_done  (pw_done)
   );

   logic unused_lvl;
   assign unused_lvl = ext_lvl;

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 2,
   parameter logic [ADDR_W-1:0] A_HI  = 0,
   parameter logic [ADDR_W-1:0] A_LO  = 1,
   parameter logic [ADDR_W-1:0] A_CTL = 2,
   localparam int CNT_W = 2 * BUS_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              irq_o,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  preload,
   input logic [BUS_W-1:0]  hold,
   input logic              run,
   input logic [1:0]        mode
);

   a_r5_ctl_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_CTL) |-> (bus_rdata[2:0] == 3'b000 && bus_rdata[5] == 1'b0));

   a_r2_lo_wr_keeps_preload: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_LO) |=> $stable(preload));

   a_r3_hi_wr_commits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_HI) |=> preload == {$past(bus_wdata), $past(hold)});

   a_r3_stopped_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_HI && !run) |=> cnt == preload);

   a_r4_hi_rd_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_HI) |=> hold == $past(cnt[BUS_W-1:0]));

   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run || mode == 2'b00) && !(bus_wr && bus_addr == A_HI)) |=> $stable(cnt));

   a_r9_irq_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(cnt) == '1 && cnt == $past(preload)));

   a_r12_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bus_wr && bus_addr == A_HI) && !irq_o)
         |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

   a_r11_autoclear_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run) && !$past(bus_wr && bus_addr == A_CTL)) |-> $past(mode) == 2'b11);

endmodule

bind evt_timer16 evt_timer16_chk #(
   .BUS_W (BUS_W), .ADDR_W (ADDR_W),
   .A_HI (A_HI), .A_LO (A_LO), .A_CTL (A_CTL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .cnt       (cnt_val),
   .preload   (preload_val),
   .hold      (hold_val),
   .run       (run_bit),
   .mode      (ctl_val[7:6])
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       ext_i = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq_o;

   int checks = 0;
   int failures = 0;
   int irq_seen = 0;

   localparam logic [1:0] AH = 2'd0, AL = 2'd1, AC = 2'd2;

   always #2 clk = ~clk;

   evt_timer16 u_evt_timer16 (
      .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .ext_i (ext_i),
      .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_o (irq_o)
   );

   always @(negedge clk) if (irq_o) irq_seen++;

   function automatic logic [7:0] ctl_byte(input logic [1:0] m, input logic run, input logic fall);
      return {m, 1'b0, run, fall, 3'b000};
   endfunction

   function automatic logic [15:0] advanced(input logic [15:0] start, input int n);
      return start + 16'(n);
   endfunction

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] h, l;
      rd(AH, h);
      rd(AL, l);
      v = {h, l};
   endtask

   task automatic load16(input logic [15:0] v);
      wr(AL, v[7:0]);
      wr(AH, v[15:8]);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         ext_i = 1'b1; idle(4);
         ext_i = 1'b0; idle(4);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] v, start;
      int n, w, irq0;
      void'($urandom(32'h5EED_0611));

      idle(5);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 irq", {15'd0, irq_o}, 16'd0);
      rd(AC, b); check("R1 ctl", {8'd0, b}, 16'd0);
      rd(AL, b); check("R1 hold", {8'd0, b}, 16'd0);
      rd16(v);   check("R1 count", v, 16'd0);

      // R5 control readback and unmapped address
      wr(AC, 8'hFF); rd(AC, b); check("R5 ctl mask", {8'd0, b}, 16'h00D8);
      wr(AC, 8'h00); rd(2'd3, b); check("R5 addr3", {8'd0, b}, 16'd0);

      // R3 stopped load, R2 low write isolation, R4 snapshot
      load16(16'hABCD);
      wr(AL, 8'h11);
      rd(AL, b); check("R2 hold write", {8'd0, b}, 16'h0011);
      rd(AH, b); check("R2 count high unchanged", {8'd0, b}, 16'h00AB);
      rd(AL, b); check("R4 snapshot low", {8'd0, b}, 16'h00CD);
      rd16(v);   check("R3 stopped load", v, 16'hABCD);

      // R6 / R12 timer mode, random starts and tick counts
      for (int it = 0; it < 12; it++) begin
         start = 16'($urandom % 32'hF000);
         n = 1 + int'($urandom % 40);
         wr(AC, ctl_byte(2'b10, 1'b0, 1'b0));
         load16(start);
         wr(AC, ctl_byte(2'b10, 1'b1, 1'b0));
         ticks(n);
         wr(AC, ctl_byte(2'b10, 1'b0, 1'b0));
         rd16(v);
         check("R6 R12 timer count", v, advanced(start, n));
      end

      // R8 run set in mode 00, then timer mode with run clear
      load16(16'h0100);
      wr(AC, ctl_byte(2'b00, 1'b1, 1'b0));
      ticks(10); ext_pulses(3);
      rd16(v); check("R8 mode off", v, 16'h0100);
      wr(AC, ctl_byte(2'b10, 1'b0, 1'b0));
      ticks(10);
      rd16(v); check("R8 run clear", v, 16'h0100);

      // R7 event mode rising then falling, tick held high and ignored
      n = 1 + int'($urandom % 8);
      ext_i = 1'b0;
      load16(16'h0200);
      tick_i = 1'b1;
      wr(AC, ctl_byte(2'b01, 1'b1, 1'b0));
      ext_pulses(n); idle(6);
      wr(AC, ctl_byte(2'b01, 1'b0, 1'b0));
      tick_i = 1'b0;
      rd16(v); check("R7 rising events", v, advanced(16'h0200, n));
      n = 1 + int'($urandom % 8);
      load16(16'h0300);
      wr(AC, ctl_byte(2'b01, 1'b1, 1'b1));
      ext_pulses(n); idle(6);
      wr(AC, ctl_byte(2'b01, 1'b0, 1'b1));
      rd16(v); check("R7 falling events", v, advanced(16'h0300, n));

      // R10 running high write, R9 wrap with reload and irq pulse
      wr(AC, 8'h00);
      load16(16'hFFFD);
      wr(AC, ctl_byte(2'b10, 1'b1, 1'b0));
      load16(16'h1234);
      rd16(v); check("R10 running write keeps count", v, 16'hFFFD);
      irq0 = irq_seen;
      ticks(3);
      wr(AC, ctl_byte(2'b10, 1'b0, 1'b0));
      rd16(v); check("R9 reload value", v, 16'h1234);
      check("R9 irq one cycle", 16'(irq_seen - irq0), 16'd1);

      // R11 pulse width, active high
      ext_i = 1'b0; tick_i = 1'b1;
      wr(AC, 8'h00);
      load16(16'h0000);
      wr(AC, ctl_byte(2'b11, 1'b1, 1'b0));
      idle(6);
      rd16(v); check("R11 waits for edge", v, 16'd0);
      w = 5 + int'($urandom % 30);
      @(negedge clk); ext_i = 1'b1;
      repeat (w) @(negedge clk);
      ext_i = 1'b0;
      idle(6);
      rd16(v); check("R11 width high", v, 16'(w - 1));
      rd(AC, b); check("R11 run cleared", {8'd0, b}, 16'h00C0);
      ext_pulses(2);
      rd16(v); check("R11 stopped after pulse", v, 16'(w - 1));

      // R11 pulse width, active low
      ext_i = 1'b1; idle(4);
      load16(16'h0000);
      wr(AC, ctl_byte(2'b11, 1'b1, 1'b1));
      idle(4);
      w = 5 + int'($urandom % 30);
      @(negedge clk); ext_i = 1'b0;
      repeat (w) @(negedge clk);
      ext_i = 1'b1;
      idle(6);
      rd16(v); check("R11 width low", v, 16'(w - 1));
      rd(AC, b); check("R11 run cleared low", {8'd0, b}, 16'h00C8);
      tick_i = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule